// File: doc/BRIEF.md
# Type 1 to Type 0 Configuration Forwarder

This block sits inside a PCI-to-PCI bridge model, between the upstream (primary) request path and the downstream (secondary) bus. It recognises configuration cycles in Type 1 form that are addressed to the bus directly below the bridge, and re-issues them downstream in Type 0 form. The device number selects a single upper address line, which serves as the device-select signal on the secondary bus. Device number 31, when the register field is zero, becomes a special cycle instead.

Each claimed request is handled as a delayed transaction. The first appearance of a request is latched and answered with retry, and the secondary cycle is then started. Every later appearance is also answered with retry until the secondary cycle finishes. After that, the next identical request collects the stored result exactly once. The block holds one delayed request at a time. It moves one 32-bit data word per transaction. A cycle that selects no device ends as a master abort.

Both sides use a simple handshake. The upstream side presents a one-cycle request and receives a registered response in the next cycle. The downstream side holds its request until it receives a one-cycle acknowledge.

Top module: `cfg_type1_fwd`

## Requirements
- R1: A request is claimed only if all three of these hold: `p_addr[1:0]` is 01, `p_cmd` is 4'hA (configuration read) or 4'hB (configuration write), and `p_addr[23:16]` equals `sec_bus`. An unclaimed request gets no response (`p_rsp_vld` stays 0) and starts no downstream cycle.
- R2: The downstream address has bits [1:0] = 00 and bits [15:11] = 0. Bits [10:2] (function and register) are copied unchanged from the upstream address.
- R3: For a device number d from 0 to 15 (taken from `p_addr[15:11]`), `s_addr[31:16]` has exactly one bit set, at position 16+d. The downstream command equals the upstream command.
- R4: For device numbers 16 to 30, `s_addr[31:16]` is all zero and the transaction completes with the abort flag set.
- R5: A configuration write to device 31 with `p_addr[7:2]` = 0 is issued downstream with command 4'h1 (special cycle), with `s_addr[31:16]` = 0, and completes without abort. A read of the same form is a configuration read that selects no device, so it aborts.
- R6: A claimed request arriving in the idle state gets a retry response in the next cycle, and `s_req` rises in that same cycle. `s_req`, `s_addr`, `s_cmd` and `s_wdata` hold steady until `s_ack`. `s_req` falls in the cycle after `s_ack`, so exactly one data word is transferred.
- R7: While the downstream cycle is outstanding, every claimed request gets retry. This includes a repeat that arrives in the same cycle as `s_ack`.
- R8: After the downstream cycle completes, the next request with the same address and command (and the same write data, for writes) gets a response with `p_rsp_retry` = 0 and the stored result, and the entry is freed. A further repeat then starts a new transaction.
- R9: A different claimed request that arrives while an entry is held gets retry and is not latched. The downstream address and the held result are unchanged.
- R10: A completion is an abort if no device was selected or if `s_mabort` is set with `s_ack`. An aborted read returns FFFFFFFFh. A write always returns data 0. A read without abort returns `s_rdata`.
- R11: An active-low reset clears the held request and the held result. After reset `s_req` and `p_rsp_vld` are 0, and an earlier request is treated as new.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| sec_bus | input | 8 | Programmed number of the bus directly below the bridge |
| p_req | input | 1 | Upstream request strobe, one cycle |
| p_addr | input | 32 | Upstream Type 1 address |
| p_cmd | input | 4 | Upstream bus command |
| p_wdata | input | 32 | Upstream write data |
| p_rsp_vld | output | 1 | Response valid, one cycle after a claimed request |
| p_rsp_retry | output | 1 | Response is a retry |
| p_rsp_abort | output | 1 | Completion ended in master abort |
| p_rsp_rdata | output | 32 | Completion read data |
| s_req | output | 1 | Downstream cycle request, held until acknowledge |
| s_addr | output | 32 | Downstream Type 0 address with device select |
| s_cmd | output | 4 | Downstream command |
| s_wdata | output | 32 | Downstream write data |
| s_ack | input | 1 | Downstream cycle finished, one cycle |
| s_rdata | input | 32 | Downstream read data, valid with `s_ack` |
| s_mabort | input | 1 | Downstream cycle ended in master abort, valid with `s_ack` |

## Verification
The delicate collision is between the completion of the downstream cycle (`s_ack`) and a retried upstream repeat, when both arrive in the same clock. The bench drives `p_req` and `s_ack` in the same cycle, both in directed cases and at random within transactions. It expects a retry in that cycle, `s_req` low in the next, and then the stored result on the following repeat. A second collision is a foreign request arriving while an entry is held. In that case the held downstream address must not change, and the original request must still collect its own data.

// File: rtl/cfgfwd_pkg.sv
package cfgfwd_pkg;

  localparam logic [3:0] CMD_CFG_RD  = 4'hA;
  localparam logic [3:0] CMD_CFG_WR  = 4'hB;
  localparam logic [3:0] CMD_SPECIAL = 4'h1;

  localparam int DEV_W     = 5;
  localparam int FNREG_W   = 9;
  localparam int BUS_W     = 8;
  localparam int SEL_LINES = 16;
  localparam int SEL_LSB   = 16;

  localparam logic [DEV_W-1:0] DEV_SPECIAL = 5'h1F;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_SEC  = 2'd1,
    ST_DONE = 2'd2
  } dly_state_e;

endpackage

// File: rtl/cfgfwd_decode.sv
module cfgfwd_decode
  import cfgfwd_pkg::*;
(
  input  logic             req,
  input  logic [1:0]       addr_lsb,
  input  logic [BUS_W-1:0] bus_fld,
  input  logic [BUS_W-1:0] sec_bus,
  input  logic [3:0]       cmd,
  output logic             claim
);

  logic is_cfg;
  logic is_type1;
  logic bus_hit;

  always_comb begin
    is_cfg   = (cmd == CMD_CFG_RD) || (cmd == CMD_CFG_WR);
    is_type1 = (addr_lsb == 2'b01);
    bus_hit  = (bus_fld == sec_bus);
    claim    = req && is_cfg && is_type1 && bus_hit;
  end

endmodule

// File: rtl/cfgfwd_xlate.sv
module cfgfwd_xlate
  import cfgfwd_pkg::*;
#(
  parameter int NUM_IDSEL = 16,
  parameter int ADDR_W    = 32
) (
  input  logic [DEV_W-1:0]   dev,
  input  logic [FNREG_W-1:0] fnreg,
  input  logic [3:0]         cmd,
  output logic [ADDR_W-1:0]  x_addr,
  output logic [3:0]         x_cmd,
  output logic               x_no_idsel
);

  localparam int GAP_W = ADDR_W - SEL_LINES - FNREG_W - 2;

  logic [SEL_LINES-1:0] idsel;
  logic                 special;

  for (genvar g = 0; g < SEL_LINES; g++) begin : g_sel
    if (g < NUM_IDSEL) begin : g_on
      assign idsel[g] = (dev == DEV_W'(g)) && !special;
    end else begin : g_off
      assign idsel[g] = 1'b0;
    end
  end

  always_comb begin
    special    = (cmd == CMD_CFG_WR) && (dev == DEV_SPECIAL) &&
                 (fnreg[5:0] == 6'd0);
    x_cmd      = special ? CMD_SPECIAL : cmd;
    x_no_idsel = (idsel == '0) && !special;
    x_addr     = {idsel, {GAP_W{1'b0}}, fnreg, 2'b00};
  end

endmodule

// File: rtl/cfgfwd_dly.sv
module cfgfwd_dly
  import cfgfwd_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              claim,
  input  logic [ADDR_W-1:0] p_addr,
  input  logic [3:0]        p_cmd,
  input  logic [DATA_W-1:0] p_wdata,
  input  logic [ADDR_W-1:0] x_addr,
  input  logic [3:0]        x_cmd,
  input  logic              x_no_idsel,
  input  logic              s_ack,
  input  logic [DATA_W-1:0] s_rdata,
  input  logic              s_mabort,
  output logic              p_rsp_vld,
  output logic              p_rsp_retry,
  output logic              p_rsp_abort,
  output logic [DATA_W-1:0] p_rsp_rdata,
  output logic              s_req,
  output logic [ADDR_W-1:0] s_addr,
  output logic [3:0]        s_cmd,
  output logic [DATA_W-1:0] s_wdata
);

  dly_state_e        state, state_n;

  logic [ADDR_W-1:0] lat_addr;
  logic [3:0]        lat_cmd;
  logic [DATA_W-1:0] lat_wdata;
  logic              lat_no_idsel;
  logic [ADDR_W-1:0] sec_addr;
  logic [3:0]        sec_cmd;
  logic [DATA_W-1:0] cpl_data;
  logic              cpl_abort;

  logic              lat_en;
  logic              cpl_en;
  logic              same;
  logic [DATA_W-1:0] cpl_data_n;
  logic              cpl_abort_n;
  logic              rsp_vld_n;
  logic              rsp_retry_n;
  logic              rsp_abort_n;
  logic [DATA_W-1:0] rsp_rdata_n;

  always_comb begin
    same = (p_addr == lat_addr) && (p_cmd == lat_cmd) &&
           ((p_cmd == CMD_CFG_RD) || (p_wdata == lat_wdata));
    cpl_abort_n = lat_no_idsel || s_mabort;
    if (lat_cmd == CMD_CFG_RD) begin
      cpl_data_n = cpl_abort_n ? {DATA_W{1'b1}} : s_rdata;
    end else begin
      cpl_data_n = '0;
    end

    state_n     = state;
    lat_en      = 1'b0;
    cpl_en      = 1'b0;
    rsp_vld_n   = claim;
    rsp_retry_n = 1'b0;
    rsp_abort_n = 1'b0;
    rsp_rdata_n = '0;

    case (state)
      ST_IDLE: begin
        if (claim) begin
          lat_en      = 1'b1;
          rsp_retry_n = 1'b1;
          state_n     = ST_SEC;
        end
      end
      ST_SEC: begin
        if (claim) begin
          rsp_retry_n = 1'b1;
        end
        if (s_ack) begin
          cpl_en  = 1'b1;
          state_n = ST_DONE;
        end
      end
      ST_DONE: begin
        if (claim) begin
          if (same) begin
            rsp_abort_n = cpl_abort;
            rsp_rdata_n = cpl_data;
            state_n     = ST_IDLE;
          end else begin
            rsp_retry_n = 1'b1;
          end
        end
      end
      default: state_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE;
    end else begin
      state <= state_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lat_addr     <= '0;
      lat_cmd      <= '0;
      lat_wdata    <= '0;
      lat_no_idsel <= 1'b0;
      sec_addr     <= '0;
      sec_cmd      <= '0;
    end else if (lat_en) begin
      lat_addr     <= p_addr;
      lat_cmd      <= p_cmd;
      lat_wdata    <= p_wdata;
      lat_no_idsel <= x_no_idsel;
      sec_addr     <= x_addr;
      sec_cmd      <= x_cmd;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cpl_data  <= '0;
      cpl_abort <= 1'b0;
    end else if (cpl_en) begin
      cpl_data  <= cpl_data_n;
      cpl_abort <= cpl_abort_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      p_rsp_vld   <= 1'b0;
      p_rsp_retry <= 1'b0;
      p_rsp_abort <= 1'b0;
      p_rsp_rdata <= '0;
    end else begin
      p_rsp_vld   <= rsp_vld_n;
      p_rsp_retry <= rsp_retry_n;
      p_rsp_abort <= rsp_abort_n;
      p_rsp_rdata <= rsp_rdata_n;
    end
  end

  always_comb begin
    s_req   = (state == ST_SEC);
    s_addr  = sec_addr;
    s_cmd   = sec_cmd;
    s_wdata = lat_wdata;
  end

  AST_SREQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    s_req && !s_ack |=> s_req && $stable(s_addr) && $stable(s_cmd) && $stable(s_wdata)); // R6

  AST_ONE_XFER: assert property (@(posedge clk) disable iff (!rst_n)
    s_req && s_ack |=> !s_req); // R6

  AST_BUSY_RETRY: assert property (@(posedge clk) disable iff (!rst_n)
    claim && (state == ST_SEC) |=> p_rsp_vld && p_rsp_retry); // R7

  AST_NO_CLAIM_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !claim |=> !p_rsp_vld); // R1

  AST_HELD_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    claim && (state != ST_IDLE) |=> $stable(s_addr) && $stable(s_cmd)); // R9

  AST_IDSEL_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    s_req |-> $onehot0(s_addr[ADDR_W-1:SEL_LSB])); // R3

  AST_ABORT_ONES: assert property (@(posedge clk) disable iff (!rst_n)
    p_rsp_vld && !p_rsp_retry && p_rsp_abort && (lat_cmd == CMD_CFG_RD)
      |-> (p_rsp_rdata == {DATA_W{1'b1}})); // R10

endmodule

// File: rtl/cfg_type1_fwd.sv
module cfg_type1_fwd
  import cfgfwd_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int DATA_W    = 32,
  parameter int NUM_IDSEL = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [7:0]        sec_bus,
  input  logic              p_req,
  input  logic [ADDR_W-1:0] p_addr,
  input  logic [3:0]        p_cmd,
  input  logic [DATA_W-1:0] p_wdata,
  output logic              p_rsp_vld,
  output logic              p_rsp_retry,
  output logic              p_rsp_abort,
  output logic [DATA_W-1:0] p_rsp_rdata,
  output logic              s_req,
  output logic [ADDR_W-1:0] s_addr,
  output logic [3:0]        s_cmd,
  output logic [DATA_W-1:0] s_wdata,
  input  logic              s_ack,
  input  logic [DATA_W-1:0] s_rdata,
  input  logic              s_mabort
);

  localparam int DEV_LSB = 11;
  localparam int BUS_LSB = 16;

  logic              claim;
  logic [ADDR_W-1:0] x_addr;
  logic [3:0]        x_cmd;
  logic              x_no_idsel;

  cfgfwd_decode u_decode (
    .req      (p_req),
    .addr_lsb (p_addr[1:0]),
    .bus_fld  (p_addr[BUS_LSB +: BUS_W]),
    .sec_bus  (sec_bus),
    .cmd      (p_cmd),
    .claim    (claim)
  );

  cfgfwd_xlate #(
    .NUM_IDSEL (NUM_IDSEL),
    .ADDR_W    (ADDR_W)
  ) u_xlate (
    .dev        (p_addr[DEV_LSB +: DEV_W]),
    .fnreg      (p_addr[2 +: FNREG_W]),
    .cmd        (p_cmd),
    .x_addr     (x_addr),
    .x_cmd      (x_cmd),
    .x_no_idsel (x_no_idsel)
  );

  cfgfwd_dly #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
  ) u_dly (
    .clk         (clk),
    .rst_n       (rst_n),
    .claim       (claim),
    .p_addr      (p_addr),
    .p_cmd       (p_cmd),
    .p_wdata     (p_wdata),
    .x_addr      (x_addr),
    .x_cmd       (x_cmd),
    .x_no_idsel  (x_no_idsel),
    .s_ack       (s_ack),
    .s_rdata     (s_rdata),
    .s_mabort    (s_mabort),
    .p_rsp_vld   (p_rsp_vld),
    .p_rsp_retry (p_rsp_retry),
    .p_rsp_abort (p_rsp_abort),
    .p_rsp_rdata (p_rsp_rdata),
    .s_req       (s_req),
    .s_addr      (s_addr),
    .s_cmd       (s_cmd),
    .s_wdata     (s_wdata)
  );

  AST_SREQ_AFTER_CLAIM: assert property (@(posedge clk) disable iff (!rst_n)
    claim && !s_req && !p_rsp_vld |=> s_req || p_rsp_vld); // R6

endmodule

// File: tb/sim_cfg_type1_fwd.sv
module sim_cfg_type1_fwd;

  logic        clk;
  logic        rst_n;
  logic [7:0]  sec_bus;
  logic        p_req;
  logic [31:0] p_addr;
  logic [3:0]  p_cmd;
  logic [31:0] p_wdata;
  logic        p_rsp_vld;
  logic        p_rsp_retry;
  logic        p_rsp_abort;
  logic [31:0] p_rsp_rdata;
  logic        s_req;
  logic [31:0] s_addr;
  logic [3:0]  s_cmd;
  logic [31:0] s_wdata;
  logic        s_ack;
  logic [31:0] s_rdata;
  logic        s_mabort;

  int nchk;
  int nfail;

  cfg_type1_fwd u0 (
    .clk(clk), .rst_n(rst_n), .sec_bus(sec_bus),
    .p_req(p_req), .p_addr(p_addr), .p_cmd(p_cmd), .p_wdata(p_wdata),
    .p_rsp_vld(p_rsp_vld), .p_rsp_retry(p_rsp_retry),
    .p_rsp_abort(p_rsp_abort), .p_rsp_rdata(p_rsp_rdata),
    .s_req(s_req), .s_addr(s_addr), .s_cmd(s_cmd), .s_wdata(s_wdata),
    .s_ack(s_ack), .s_rdata(s_rdata), .s_mabort(s_mabort)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  function automatic logic is_special(input logic [31:0] a, input logic [3:0] c);
    return (c == 4'hB) && (a[15:11] == 5'h1F) && (a[7:2] == 6'd0);
  endfunction

  function automatic logic [31:0] exp_saddr(input logic [31:0] a, input logic [3:0] c);
    logic [15:0] up;
    up = (a[15:11] < 5'd16 && !is_special(a, c)) ? (16'd1 << a[15:11]) : 16'd0;
    return {up, 5'd0, a[10:2], 2'b00};
  endfunction

  function automatic logic [3:0] exp_scmd(input logic [31:0] a, input logic [3:0] c);
    return is_special(a, c) ? 4'h1 : c;
  endfunction

  function automatic logic exp_abort(input logic [31:0] a, input logic [3:0] c, input logic mab);
    return ((a[15:11] >= 5'd16) && !is_special(a, c)) || mab;
  endfunction

  function automatic logic [31:0] exp_rdata(input logic [31:0] a, input logic [3:0] c,
                                            input logic mab, input logic [31:0] rd);
    if (c != 4'hA) return 32'd0;
    return exp_abort(a, c, mab) ? 32'hFFFF_FFFF : rd;
  endfunction

  function automatic logic [31:0] mk_addr(input logic [4:0] dev, input logic [8:0] fr,
                                          input logic [7:0] top);
    return {top, sec_bus, dev, fr, 2'b01};
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic send(input logic [31:0] a, input logic [3:0] c, input logic [31:0] w,
                      input logic with_ack, input logic mab, input logic [31:0] rd);
    @(negedge clk);
    p_req = 1'b1; p_addr = a; p_cmd = c; p_wdata = w;
    if (with_ack) begin
      s_ack = 1'b1; s_mabort = mab; s_rdata = rd;
    end
    @(negedge clk);
    p_req = 1'b0; s_ack = 1'b0; s_mabort = 1'b0;
  endtask

  task automatic ack(input logic mab, input logic [31:0] rd);
    @(negedge clk);
    s_ack = 1'b1; s_mabort = mab; s_rdata = rd;
    @(negedge clk);
    s_ack = 1'b0; s_mabort = 1'b0;
  endtask

  task automatic xact(input logic [31:0] a, input logic [3:0] c, input logic [31:0] w,
                      input int dly, input logic mab, input logic [31:0] rd, input logic collide);
    logic [31:0] ea;
    ea = exp_saddr(a, c);
    send(a, c, w, 1'b0, 1'b0, 32'd0);
    chk(p_rsp_vld && p_rsp_retry, "R6 first response retry", {30'd0, p_rsp_vld, p_rsp_retry}, 32'd3);
    chk(s_req, "R6 s_req raised", {31'd0, s_req}, 32'd1);
    chk(s_addr[15:0] == ea[15:0], "R2 low address", s_addr, ea);
    chk(s_addr[31:16] == ea[31:16], "R3 R4 idsel field", s_addr, ea);
    chk(s_cmd == exp_scmd(a, c), "R5 downstream command", {28'd0, s_cmd}, {28'd0, exp_scmd(a, c)});
    chk(c != 4'hB || s_wdata == w, "R6 write data", s_wdata, w);
    for (int i = 0; i < dly; i++) begin
      send(a, c, w, 1'b0, 1'b0, 32'd0);
      chk(p_rsp_vld && p_rsp_retry, "R7 retry while busy", {30'd0, p_rsp_vld, p_rsp_retry}, 32'd3);
      chk(s_req && s_addr == ea, "R6 held request", s_addr, ea);
    end
    if (collide) begin
      send(a, c, w, 1'b1, mab, rd);
      chk(p_rsp_vld && p_rsp_retry, "R7 retry on ack cycle", {30'd0, p_rsp_vld, p_rsp_retry}, 32'd3);
    end else begin
      ack(mab, rd);
    end
    chk(!s_req, "R6 single transfer", {31'd0, s_req}, 32'd0);
    send(a, c, w, 1'b0, 1'b0, 32'd0);
    chk(p_rsp_vld && !p_rsp_retry, "R8 completion delivered", {30'd0, p_rsp_vld, p_rsp_retry}, 32'd2);
    chk(p_rsp_abort == exp_abort(a, c, mab), "R10 R4 abort flag",
        {31'd0, p_rsp_abort}, {31'd0, exp_abort(a, c, mab)});
    chk(p_rsp_rdata == exp_rdata(a, c, mab, rd), "R10 read data",
        p_rsp_rdata, exp_rdata(a, c, mab, rd));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nfail++;
    $display("FAIL R6 watchdog actual=hung expected=finish");
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

  initial begin
    logic [31:0] a;
    logic [31:0] b;
    int seed;
    nchk = 0; nfail = 0;
    rst_n = 1'b0; sec_bus = 8'h5C; p_req = 1'b0; p_addr = '0; p_cmd = '0;
    p_wdata = '0; s_ack = 1'b0; s_rdata = '0; s_mabort = 1'b0;
    seed = $urandom(32'd2024);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!s_req && !p_rsp_vld, "R11 reset state", {30'd0, s_req, p_rsp_vld}, 32'd0);

    // R1 unclaimed: wrong bus, wrong low bits, wrong command
    a = mk_addr(5'd3, 9'd4, 8'd0);
    send({a[31:24], 8'h11, a[15:0]}, 4'hA, 32'd0, 1'b0, 1'b0, 32'd0);
    chk(!p_rsp_vld && !s_req, "R1 bus mismatch ignored", {30'd0, p_rsp_vld, s_req}, 32'd0);
    send({a[31:2], 2'b00}, 4'hA, 32'd0, 1'b0, 1'b0, 32'd0);
    chk(!p_rsp_vld && !s_req, "R1 type0 ignored", {30'd0, p_rsp_vld, s_req}, 32'd0);
    send(a, 4'h6, 32'd0, 1'b0, 1'b0, 32'd0);
    chk(!p_rsp_vld && !s_req, "R1 memory cmd ignored", {30'd0, p_rsp_vld, s_req}, 32'd0);

    // R3 edge devices, R4 no select, R5 special cycle
    xact(mk_addr(5'd0, 9'h1FF, 8'hAB), 4'hA, 32'd0, 1, 1'b0, 32'h1234_5678, 1'b0);
    xact(mk_addr(5'd15, 9'h0A5, 8'h00), 4'hB, 32'hCAFE_0001, 0, 1'b0, 32'd0, 1'b0);
    xact(mk_addr(5'd16, 9'h010, 8'h00), 4'hA, 32'd0, 1, 1'b0, 32'h0BAD_0BAD, 1'b0);
    xact(mk_addr(5'd30, 9'h010, 8'h00), 4'hB, 32'h7, 0, 1'b0, 32'd0, 1'b0);
    xact(mk_addr(5'h1F, 9'h1C0, 8'h00), 4'hB, 32'h00AA_5501, 1, 1'b0, 32'd0, 1'b0);
    xact(mk_addr(5'h1F, 9'h000, 8'h00), 4'hA, 32'd0, 0, 1'b0, 32'h55, 1'b0);
    xact(mk_addr(5'h1F, 9'h004, 8'h00), 4'hB, 32'h9, 0, 1'b0, 32'd0, 1'b0);
    // R10 downstream master abort, R7 ack collision
    xact(mk_addr(5'd7, 9'h022, 8'h00), 4'hA, 32'd0, 2, 1'b1, 32'h1111_2222, 1'b1);
    xact(mk_addr(5'd9, 9'h033, 8'h00), 4'hB, 32'h4444, 0, 1'b1, 32'd0, 1'b1);

    // R9 foreign request while held
    a = mk_addr(5'd2, 9'h044, 8'h00);
    b = mk_addr(5'd4, 9'h044, 8'h00);
    send(a, 4'hA, 32'd0, 1'b0, 1'b0, 32'd0);
    send(b, 4'hA, 32'd0, 1'b0, 1'b0, 32'd0);
    chk(p_rsp_vld && p_rsp_retry, "R9 foreign retried", {30'd0, p_rsp_vld, p_rsp_retry}, 32'd3);
    chk(s_addr == exp_saddr(a, 4'hA), "R9 latch kept", s_addr, exp_saddr(a, 4'hA));
    ack(1'b0, 32'hDEAD_BEEF);
    send(b, 4'hA, 32'd0, 1'b0, 1'b0, 32'd0);
    chk(p_rsp_vld && p_rsp_retry, "R9 foreign retried after done", {30'd0, p_rsp_vld, p_rsp_retry}, 32'd3);
    send(a, 4'hB, 32'd0, 1'b0, 1'b0, 32'd0);
    chk(p_rsp_retry, "R8 command must match", {31'd0, p_rsp_retry}, 32'd1);
    send(a, 4'hA, 32'd0, 1'b0, 1'b0, 32'd0);
    chk(!p_rsp_retry && p_rsp_rdata == 32'hDEAD_BEEF, "R9 original completes", p_rsp_rdata, 32'hDEAD_BEEF);
    send(a, 4'hA, 32'd0, 1'b0, 1'b0, 32'd0);
    chk(p_rsp_retry && s_req, "R8 repeat after delivery is new", {30'd0, p_rsp_retry, s_req}, 32'd3);
    ack(1'b0, 32'd1);
    send(a, 4'hA, 32'd0, 1'b0, 1'b0, 32'd0);
    chk(!p_rsp_retry && p_rsp_rdata == 32'd1, "R8 second delivery", p_rsp_rdata, 32'd1);

    // R8 write data must match
    a = mk_addr(5'd5, 9'h011, 8'h00);
    send(a, 4'hB, 32'h100, 1'b0, 1'b0, 32'd0);
    ack(1'b0, 32'd0);
    send(a, 4'hB, 32'h101, 1'b0, 1'b0, 32'd0);
    chk(p_rsp_retry, "R8 write data mismatch retried", {31'd0, p_rsp_retry}, 32'd1);
    send(a, 4'hB, 32'h100, 1'b0, 1'b0, 32'd0);
    chk(!p_rsp_retry && !p_rsp_abort, "R8 write completes", {30'd0, p_rsp_retry, p_rsp_abort}, 32'd0);

    // R11 reset while pending
    a = mk_addr(5'd6, 9'h012, 8'h00);
    send(a, 4'hA, 32'd0, 1'b0, 1'b0, 32'd0);
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    chk(!s_req && !p_rsp_vld, "R11 reset clears pending", {30'd0, s_req, p_rsp_vld}, 32'd0);
    xact(a, 4'hA, 32'd0, 0, 1'b0, 32'h600D, 1'b0);

    // random mix
    for (int n = 0; n < 150; n++) begin
      logic [4:0]  dv;
      logic [3:0]  cm;
      logic        mb;
      dv = 5'($urandom_range(0, 31));
      cm = ($urandom_range(0, 1) == 0) ? 4'hA : 4'hB;
      mb = ($urandom_range(0, 9) == 0);
      a  = mk_addr(dv, 9'($urandom), 8'($urandom));
      if ($urandom_range(0, 5) == 0) a[7:2] = 6'd0;
      xact(a, cm, $urandom, $urandom_range(0, 3), mb, $urandom, $urandom_range(0, 2) == 0);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

endmodule